// File: doc/BRIEF.md
# Speculative ECC Read-Return Path

This block sits on the cache-hit read path between a data array and the unit that asked for the data. Each array beat carries a 64-bit word and 8 check bits. In its normal, speculative state the block hands the raw word to the requester one cycle after it arrives. A two-stage SECDED checker examines the same beat in parallel. The requester therefore gets data at the lowest latency and learns about a bad beat only after it has been delivered.

When the checker flags an error on a beat that was already forwarded, the block raises a discard strobe. A two-bit mask on the strobe names the delivered beats to throw away: the bad beat, and the beat forwarded in the cycle after it. In that same cycle the output switches to the end of the checker pipeline. From then on every beat goes out after correction, with two extra cycles of latency, and the thrown-away beats are delivered again, in order. The block falls back to speculative forwarding once the return channel has drained. Checking is active only while the ECC enable input is high, and that input is meant to be set before caching is turned on. Double-bit errors are passed through uncorrected, carry an error response, and set a sticky flag.

Top module: `ecc_spec_return`

## Requirements
- R1: After a synchronous active-low reset, out_valid, discard_valid and ue_flag are all low.
- R2: In speculative mode, a beat presented with in_valid high is output on out_data/out_valid one clock later, unchanged.
- R3: The code is a Hamming SECDED code over a 72-bit codeword. Codeword positions 1..71 hold the data bits in ascending order at every position that is not a power of two. in_check[6:0] is the XOR of the position numbers of all set data bits. in_check[7] makes the XOR of all 72 bits zero. With ecc_en high, any single flipped bit among the 72 is corrected in the stream the requester keeps after discards.
- R4: With ecc_en high, in speculative mode, a beat with an error causes discard_valid to pulse for one cycle, two cycles after that beat was forwarded. discard_mask[1] marks the bad beat and is always 1. discard_mask[0] is 1 exactly when a beat was forwarded in the cycle after the bad beat.
- R5: From the discard cycle on, the output comes from the correction stage: the bad beat and every later beat are delivered in order three cycles after input. The kept stream (delivered beats minus discarded ones) equals the sent stream with no loss or duplication.
- R6: While in corrected mode, further errors produce no discard strobe.
- R7: Corrected mode ends once in_valid has been low for three consecutive cycles, and a beat sent next has one-cycle latency again. If in_valid is low for only one cycle, latency stays three cycles.
- R8: A double-bit error (overall parity even, non-zero syndrome) is discarded and replayed like R4/R5. The replayed beat carries out_err high and its data exactly as received. ue_flag then rises and stays high until reset.
- R9: With ecc_en low, no checking takes place. Flipped bits pass through raw with one-cycle latency, and there is no discard, no out_err and no change of ue_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ecc_en | input | 1 | Enables error checking and correction |
| in_valid | input | 1 | Array beat present |
| in_data | input | 64 | Array data word |
| in_check | input | 8 | SECDED check bits of the beat |
| out_valid | output | 1 | Beat delivered to requester |
| out_data | output | 64 | Delivered data |
| out_err | output | 1 | Error response: uncorrectable beat |
| discard_valid | output | 1 | Drop previously delivered beats |
| discard_mask | output | 2 | [1] bad beat, [0] beat forwarded one cycle after it |
| ue_flag | output | 1 | Sticky uncorrectable-error flag |

## Verification
A mode register stuck in the wrong state shows at once as wrong latency: the first beat after a drain arrives in the third cycle instead of the first, or a replay is missing and the kept stream loses a word. A wrong mask or a misplaced discard pulse corrupts the kept stream in the same burst, with a missing or duplicated beat. A bad syndrome-to-bit mapping shows up as a wrong corrected word for one particular bit position. The bench therefore sweeps a flip over all 72 positions and compares the kept stream beat by beat after each burst.

// File: rtl/ecc_ret_pkg.sv
// Package: shared widths, beat type and SECDED helper functions.
// Assumes a Hamming layout where data fills non-power-of-two positions 1..N.
package ecc_ret_pkg;
    parameter int DATA_W = 64;
    localparam int PAR_W  = $clog2(DATA_W + $clog2(DATA_W) + 1);
    localparam int CHK_W  = PAR_W + 1;
    localparam int CW_LEN = DATA_W + PAR_W;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [CHK_W-1:0]  chk;
    } beat_t;

    // XOR of the codeword positions of all set data bits
    function automatic logic [PAR_W-1:0] hamming_par(input logic [DATA_W-1:0] d);
        logic [PAR_W-1:0] acc;
        int k;
        acc = '0;
        k   = 0;
        for (int pos = 1; pos <= CW_LEN; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                if (d[k]) acc ^= pos[PAR_W-1:0];
                k++;
            end
        end
        return acc;
    endfunction

    // Flip the data bit that sits at codeword position syn (no-op otherwise)
    function automatic logic [DATA_W-1:0] flip_at(input logic [DATA_W-1:0] d,
                                                  input logic [PAR_W-1:0]  syn);
        logic [DATA_W-1:0] r;
        int k;
        r = d;
        k = 0;
        for (int pos = 1; pos <= CW_LEN; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                if (pos[PAR_W-1:0] == syn) r[k] = ~r[k];
                k++;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/ecc_syn_stage.sv
// Syndrome stage: registers a beat and its Hamming syndrome plus overall parity.
// Assumes check bits arrive with the beat; payload registers need no reset.
module ecc_syn_stage
    import ecc_ret_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  beat_t             beat_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic [PAR_W-1:0]  syn_o,
    output logic              par_o
);
    // Valid bit of the stage, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= beat_i.valid;
    end

    // Payload, syndrome and total parity of the received codeword
    always_ff @(posedge clk) begin
        data_o <= beat_i.data;
        syn_o  <= hamming_par(beat_i.data) ^ beat_i.chk[PAR_W-1:0];
        par_o  <= (^beat_i.data) ^ (^beat_i.chk);
    end
endmodule

// File: rtl/ecc_fix_stage.sv
// Correction stage: classifies the syndrome and flips the faulty data bit.
// Assumes syndrome and parity are aligned with the data on the input.
module ecc_fix_stage
    import ecc_ret_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_en_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [PAR_W-1:0]  syn_i,
    input  logic              par_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              sbe_o,
    output logic              dbe_o
);
    logic single_w, double_w;

    // Odd total parity means one flip; even parity with a syndrome means two
    always_comb begin
        single_w = ecc_en_i && valid_i && par_i;
        double_w = ecc_en_i && valid_i && !par_i && (syn_i != '0);
    end

    // Valid and error flags of the stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            sbe_o   <= 1'b0;
            dbe_o   <= 1'b0;
        end else begin
            valid_o <= valid_i;
            sbe_o   <= single_w;
            dbe_o   <= double_w;
        end
    end

    // Corrected data; double-bit beats pass unchanged
    always_ff @(posedge clk) begin
        data_o <= single_w ? flip_at(data_i, syn_i) : data_i;
    end

    // R9: a disabled checker never raises an error flag
    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ecc_en_i |=> !(sbe_o || dbe_o));
    // R3: one beat is never both single- and double-bit
    p_class_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sbe_o && dbe_o));
endmodule

// File: rtl/ecc_mode_ctrl.sv
// Mode control: picks raw or corrected output, issues discards, keeps the
// sticky uncorrectable flag. Assumes stage 3 carries check results for a beat
// that was forwarded raw two cycles earlier while in speculative mode.
module ecc_mode_ctrl
    import ecc_ret_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v1_i,
    input  logic [DATA_W-1:0] d1_i,
    input  logic              v2_i,
    input  logic              v3_i,
    input  logic [DATA_W-1:0] d3_i,
    input  logic              sbe3_i,
    input  logic              dbe3_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_data_o,
    output logic              out_err_o,
    output logic              discard_o,
    output logic [1:0]        mask_o,
    output logic              ue_o
);
    logic corr_q;
    logic ue_q;
    logic err_now, use_fix, drained;

    // Output source select and discard generation
    always_comb begin
        err_now     = v3_i && (sbe3_i || dbe3_i);
        use_fix     = corr_q || err_now;
        drained     = !(v1_i || v2_i || v3_i);
        out_valid_o = use_fix ? v3_i : v1_i;
        out_data_o  = use_fix ? d3_i : d1_i;
        out_err_o   = use_fix && v3_i && dbe3_i;
        discard_o   = !corr_q && err_now;
        mask_o      = discard_o ? {1'b1, v2_i} : 2'b00;
        ue_o        = ue_q;
    end

    // Mode register: enter on an error, leave once the pipeline is empty
    always_ff @(posedge clk) begin
        if (!rst_n)       corr_q <= 1'b0;
        else if (!corr_q) corr_q <= err_now;
        else if (drained) corr_q <= 1'b0;
    end

    // Sticky uncorrectable-error flag
    always_ff @(posedge clk) begin
        if (!rst_n) ue_q <= 1'b0;
        else        ue_q <= ue_q || (v3_i && dbe3_i);
    end

    // R5: a discard is followed by corrected-mode output
    p_discard_enters_fix_r5: assert property (@(posedge clk) disable iff (!rst_n)
        discard_o |=> corr_q);
    // R6: no discard while already correcting
    p_no_discard_in_fix_r6: assert property (@(posedge clk) disable iff (!rst_n)
        corr_q |-> !discard_o);
    // R8: the uncorrectable flag never falls outside reset
    p_ue_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ue_q |=> ue_q);
    // R8: error response only on a delivered beat
    p_err_on_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_err_o |-> out_valid_o);
endmodule

// File: rtl/ecc_spec_return.sv
// Top: speculative read-return path. Stage 1 forwards raw data; stages 2-3
// check and correct; the mode controller chooses the output and discards.
// Assumes one beat per cycle at most and no back-pressure from the requester.
module ecc_spec_return
    import ecc_ret_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CHK_W-1:0]  in_check,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_err,
    output logic              discard_valid,
    output logic [1:0]        discard_mask,
    output logic              ue_flag
);
    beat_t             s1_q;
    logic              v2, par2, v3, sbe3, dbe3;
    logic [DATA_W-1:0] d2, d3;
    logic [PAR_W-1:0]  syn2;

    // Stage 1 valid bit
    always_ff @(posedge clk) begin
        if (!rst_n) s1_q.valid <= 1'b0;
        else        s1_q.valid <= in_valid;
    end

    // Stage 1 payload
    always_ff @(posedge clk) begin
        s1_q.data <= in_data;
        s1_q.chk  <= in_check;
    end

    ecc_syn_stage u_syn (
        .clk     (clk),
        .rst_n   (rst_n),
        .beat_i  (s1_q),
        .valid_o (v2),
        .data_o  (d2),
        .syn_o   (syn2),
        .par_o   (par2)
    );

    ecc_fix_stage u_fix (
        .clk      (clk),
        .rst_n    (rst_n),
        .ecc_en_i (ecc_en),
        .valid_i  (v2),
        .data_i   (d2),
        .syn_i    (syn2),
        .par_i    (par2),
        .valid_o  (v3),
        .data_o   (d3),
        .sbe_o    (sbe3),
        .dbe_o    (dbe3)
    );

    ecc_mode_ctrl u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .v1_i        (s1_q.valid),
        .d1_i        (s1_q.data),
        .v2_i        (v2),
        .v3_i        (v3),
        .d3_i        (d3),
        .sbe3_i      (sbe3),
        .dbe3_i      (dbe3),
        .out_valid_o (out_valid),
        .out_data_o  (out_data),
        .out_err_o   (out_err),
        .discard_o   (discard_valid),
        .mask_o      (discard_mask),
        .ue_o        (ue_flag)
    );

    // R4: the discard mask always names the faulty beat
    p_mask_names_bad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        discard_valid |-> discard_mask[1]);
    // R4: no mask bits without a discard strobe
    p_mask_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !discard_valid |-> (discard_mask == 2'b00));
endmodule

// File: tb/ecc_spec_return_test.sv
module ecc_spec_return_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ecc_en = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_check = '0;
    logic        out_valid, out_err, discard_valid, ue_flag;
    logic [63:0] out_data;
    logic [1:0]  discard_mask;

    int n_chk = 0;
    int n_err = 0;

    logic [63:0] got_d [0:63];
    logic        got_e [0:63];
    int          got_n = 0;
    int          disc_n = 0;
    logic [1:0]  disc_m = 2'b00;
    logic [71:0] fl [0:7];

    always #(CLK_P/2) clk = ~clk;

    ecc_spec_return uut (
        .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .in_valid(in_valid),
        .in_data(in_data), .in_check(in_check), .out_valid(out_valid),
        .out_data(out_data), .out_err(out_err), .discard_valid(discard_valid),
        .discard_mask(discard_mask), .ue_flag(ue_flag)
    );

    // Bench encoder written from R3
    function automatic logic [7:0] enc(input logic [63:0] d);
        logic [6:0] p;
        int pos;
        p = '0;
        pos = 1;
        for (int k = 0; k < 64; k++) begin
            pos++;
            while ((pos & (pos - 1)) == 0) pos++;
            if (d[k]) p ^= 7'(pos);
        end
        return {(^d) ^ (^p), p};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Kept-stream monitor: apply discards, then append the current beat
    always @(negedge clk) begin
        if (rst_n) begin
            if (discard_valid) begin
                disc_n++;
                disc_m = discard_mask;
                got_n -= $countones(discard_mask);
                if (got_n < 0) got_n = 0;
            end
            if (out_valid && got_n < 64) begin
                got_d[got_n] = out_data;
                got_e[got_n] = out_err;
                got_n++;
            end
        end
    end

    task automatic send(input logic [63:0] d, input logic [71:0] f);
        {in_check, in_data} = {enc(d), d} ^ f;
        in_valid = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [63:0] pat(input int base, input int i);
        return {32'(base * 7 + i * 13 + 1) ^ 32'hA5A5_0F0F, 32'(base * 31 + i)};
    endfunction

    // Send a burst with per-beat flips fl[], then compare the kept stream
    task automatic burst(input int n, input int base, input int exp_disc,
                         input logic [1:0] exp_mask, input string req);
        logic [63:0] e;
        logic        ee;
        got_n = 0;
        disc_n = 0;
        for (int i = 0; i < n; i++) send(pat(base, i), fl[i]);
        idle(4);
        check(got_n == n, req, 64'(got_n), 64'(n));
        for (int i = 0; i < n; i++) begin
            if (!ecc_en)                     begin e = pat(base, i) ^ fl[i][63:0]; ee = 1'b0; end
            else if ($countones(fl[i]) == 2) begin e = pat(base, i) ^ fl[i][63:0]; ee = 1'b1; end
            else                             begin e = pat(base, i);               ee = 1'b0; end
            check(got_d[i] == e && got_e[i] == ee, req, got_d[i], e);
        end
        check(disc_n == exp_disc, req, 64'(disc_n), 64'(exp_disc));
        if (exp_disc > 0) check(disc_m == exp_mask, req, 64'(disc_m), 64'(exp_mask));
        for (int i = 0; i < 8; i++) fl[i] = '0;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_err++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) fl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!out_valid && !discard_valid && !ue_flag, "R1", {61'd0, out_valid, discard_valid, ue_flag}, 64'd0);

        // R2: one-cycle raw latency
        send(64'h0123_4567_89AB_CDEF, '0);
        in_valid = 1'b0;
        check(out_valid && out_data == 64'h0123_4567_89AB_CDEF, "R2", out_data, 64'h0123_4567_89AB_CDEF);
        idle(4);
        burst(5, 1, 0, 2'b00, "R2");

        // R3 R4 R5: single flip swept over all 72 codeword bits
        for (int f = 0; f < 72; f++) begin
            fl[f % 4] = 72'(1) << f;
            burst(4, 100 + f, 1, (f % 4 == 3) ? 2'b10 : 2'b11, "R3/R4/R5");
        end

        // R6: second error while correcting gives no second discard
        fl[1] = 72'(1) << 5;
        fl[3] = 72'(1) << 40;
        burst(6, 300, 1, 2'b11, "R6");

        // R7: one idle cycle keeps corrected latency
        send(pat(400, 0), 72'(1) << 0);
        send(pat(400, 1), '0);
        send(pat(400, 2), '0);
        idle(1);
        send(64'hFEED_0000_BEEF_0001, '0);
        idle(2);
        check(out_valid && out_data == 64'hFEED_0000_BEEF_0001, "R7 short idle", out_data, 64'hFEED_0000_BEEF_0001);
        idle(4);
        // R7: three idle cycles restore one-cycle latency
        send(pat(401, 0), 72'(1) << 9);
        send(pat(401, 1), '0);
        idle(3);
        send(64'hCAFE_0000_0000_0002, '0);
        in_valid = 1'b0;
        check(out_valid && out_data == 64'hCAFE_0000_0000_0002, "R7 drained", out_data, 64'hCAFE_0000_0000_0002);
        idle(4);

        // R9: checking disabled
        ecc_en = 1'b0;
        idle(1);
        fl[1] = 72'(1) << 7;
        burst(4, 500, 0, 2'b00, "R9");
        fl[2] = (72'(1) << 3) | (72'(1) << 17);
        burst(4, 501, 0, 2'b00, "R9");
        check(!ue_flag, "R9", {63'd0, ue_flag}, 64'd0);
        ecc_en = 1'b1;
        idle(1);

        // R8: double-bit error
        check(!ue_flag, "R8", {63'd0, ue_flag}, 64'd0);
        fl[2] = (72'(1) << 3) | (72'(1) << 17);
        burst(4, 600, 1, 2'b11, "R8");
        check(ue_flag, "R8", {63'd0, ue_flag}, 64'd1);
        burst(3, 601, 0, 2'b00, "R8");
        check(ue_flag, "R8 sticky", {63'd0, ue_flag}, 64'd1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule